// File: doc/BRIEF.md
# Legacy TPM interface register window

This block is a byte-wide register window that a host reaches through plain I/O reads and writes. It sits in front of a TPM command engine. The window covers six consecutive byte offsets above a programmable base address. It claims accesses only while the logical device is activated, and it ignores every other address without answering.

Inside the window the host finds three kinds of byte. The interrupt enable and interrupt status registers live here. Two live status bytes come from the command engine: the low status flags and the burst count. A fixed capability byte is also readable, and one port gives access to the command and response FIFOs.

The block watches the engine's status flags and its locality ownership and turns selected transitions into sticky interrupt-status bits. A level interrupt request is raised whenever an enabled status bit is set and the device is activated. Serial interrupt framing and the command execution itself sit outside this block; the engine is reached only through its status inputs and the FIFO strobes.

Top module: `legacy_tpm_regwin`

## Requirements
- R1: With `cfg_active` high, an access (one-cycle `io_rd` or `io_wr`) to `cfg_base+0` .. `cfg_base+5` is claimed. `rsp_valid` is high in the cycle after the strobe. For a read, `rd_data` carries the byte in that same cycle. Offset 0 is interrupt enable, 1 is interrupt status, 2 is capability, 3 is engine status flags, 4 is burst count and 5 is FIFO data.
- R2: An address below `cfg_base`, or at `cfg_base+6` or above, gets no response: `rsp_valid` stays low, no FIFO strobe fires and no register changes. The window does not wrap past the top of the address space.
- R3: With `cfg_active` low, no access is claimed and `irq` is low.
- R4: Interrupt enable (offset 0) resets to 0. Only bits 7, 2, 1 and 0 are writable, and the other bits read 0.
- R5: Interrupt status (offset 1) bits are sticky and reset to 0. Bit 0 is data-available, bit 1 is status-valid, bit 2 is locality-change and bit 7 is command-ready. Writing 1 to a bit clears it, and writing 0 leaves it. An event arriving in the same cycle as a clear wins.
- R6: Offset 2 reads the `CAP_LO` parameter (default 8'h5F), offset 3 reads `eng_sts` and offset 4 reads `eng_burst`. Writes to these three offsets change nothing.
- R7: A 0-to-1 change of `eng_sts[6]` (command ready) sets status bit 7. A 0-to-1 change of `eng_sts[7]` (status valid) sets status bit 1. The status bit is visible in the cycle after the first cycle the new input value is present.
- R8: Status bit 0 is set in two cases: `eng_sts[4]` (data available) rises while `eng_sts[7]` is 1, or `eng_sts[7]` rises while `eng_sts[4]` is 1. A rise of `eng_sts[4]` while `eng_sts[7]` is 0 does not set it.
- R9: Status bit 2 is set when a locality becomes active (`eng_loc_act` goes high, or `eng_loc_id` changes while it is high), but only if some locality was active at an earlier cycle since reset. The first ownership after reset and any release do not set it.
- R10: `irq` equals `cfg_active` AND the OR of (status AND enable). It follows register changes with no further delay.
- R11: A claimed read of offset 5 returns the `fifo_rdata` value present in the strobe cycle and pulses `fifo_pop` for one cycle together with `rsp_valid`. A claimed write of offset 5 pulses `fifo_push` for one cycle with the written byte on `fifo_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| cfg_base | input | ADDR_W | Window base address |
| cfg_active | input | 1 | Logical device activated |
| eng_sts | input | 8 | Engine status flags (bit 7 valid, bit 6 command ready, bit 4 data available) |
| eng_burst | input | 8 | Engine burst count |
| eng_loc_act | input | 1 | Some locality currently owns the engine |
| eng_loc_id | input | 3 | Owning locality number |
| fifo_rdata | input | 8 | Head byte of response FIFO |
| rd_data | output | 8 | Read response byte |
| rsp_valid | output | 1 | Access was claimed |
| irq | output | 1 | Level interrupt request |
| fifo_pop | output | 1 | Pop strobe for response FIFO |
| fifo_push | output | 1 | Push strobe for command FIFO |
| fifo_wdata | output | 8 | Byte pushed into command FIFO |

## Verification
A wrong decode shows one cycle after the strobe. A missing or extra `rsp_valid` or FIFO strobe appears, or the wrong byte is returned. A stale edge register or a wrong qualification in the event logic shows up on the next status read as an interrupt-status bit that is set or missing. The same fault also reaches `irq` in that cycle if the bit is enabled. A fault in the locality ownership tracking stays hidden until the second ownership after reset, so the bench drives a sequence of acquire, switch, release and reacquire steps.

// File: rtl/tpmwin_pkg.sv
package tpmwin_pkg;
  localparam int NUM_OFS      = 6;
  localparam int OFS_INT_EN   = 0;
  localparam int OFS_INT_STAT = 1;
  localparam int OFS_CAP      = 2;
  localparam int OFS_STS_LO   = 3;
  localparam int OFS_STS_HI   = 4;
  localparam int OFS_FIFO     = 5;

  // engine status flag positions
  localparam int SF_VALID  = 7;
  localparam int SF_CMDRDY = 6;
  localparam int SF_DAVAIL = 4;

  // interrupt bit positions
  localparam int IB_DAVAIL = 0;
  localparam int IB_VALID  = 1;
  localparam int IB_LOC    = 2;
  localparam int IB_CMDRDY = 7;
  localparam logic [7:0] IRQ_MASK = 8'h87;

  function automatic logic [7:0] sts_events(input logic [7:0] cur,
                                            input logic [7:0] prv,
                                            input logic       loc_evt);
    logic [7:0] e;
    logic rise_v, rise_d;
    rise_v = cur[SF_VALID] & ~prv[SF_VALID];
    rise_d = cur[SF_DAVAIL] & ~prv[SF_DAVAIL];
    e = '0;
    e[IB_CMDRDY] = cur[SF_CMDRDY] & ~prv[SF_CMDRDY];
    e[IB_VALID]  = rise_v;
    e[IB_DAVAIL] = (rise_d & cur[SF_VALID]) | (rise_v & cur[SF_DAVAIL]);
    e[IB_LOC]    = loc_evt;
    return e;
  endfunction

  function automatic logic [7:0] stat_next(input logic [7:0] q,
                                           input logic       we,
                                           input logic [7:0] wd,
                                           input logic [7:0] evt);
    logic [7:0] clr;
    clr = we ? (wd & IRQ_MASK) : 8'h00;
    return ((q & ~clr) | evt) & IRQ_MASK;
  endfunction
endpackage

// File: rtl/tpmwin_decode.sv
module tpmwin_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              active,
  input  logic              rd,
  input  logic              wr,
  output logic              claim_rd,
  output logic              claim_wr,
  output logic [2:0]        ofs
);
  import tpmwin_pkg::*;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_OFS);

  logic [ADDR_W-1:0] diff;
  logic              hit;

  always_comb begin
    diff = addr - base;
    hit  = active && (addr >= base) && (diff < SPAN);
    ofs  = diff[2:0];
    claim_wr = hit && wr;
    claim_rd = hit && rd && !wr;
  end
endmodule

// File: rtl/tpmwin_events.sv
module tpmwin_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sts,
  input  logic       loc_act,
  input  logic [2:0] loc_id,
  output logic [7:0] evt
);
  import tpmwin_pkg::*;

  logic [7:0] prv_sts;
  logic       prv_act;
  logic [2:0] prv_id;
  logic       had_owner;
  logic       loc_evt;

  always_comb begin
    loc_evt = loc_act && had_owner && (!prv_act || (loc_id != prv_id));
    evt     = sts_events(sts, prv_sts, loc_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_sts   <= '0;
      prv_act   <= 1'b0;
      prv_id    <= '0;
      had_owner <= 1'b0;
    end else begin
      prv_sts   <= sts;
      prv_act   <= loc_act;
      prv_id    <= loc_id;
      had_owner <= had_owner | loc_act;
    end
  end
endmodule

// File: rtl/tpmwin_irqregs.sv
module tpmwin_irqregs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_we,
  input  logic       stat_we,
  input  logic [7:0] wdata,
  input  logic [7:0] evt,
  input  logic       active,
  output logic [7:0] en_q,
  output logic [7:0] stat_q,
  output logic       irq
);
  import tpmwin_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_we) en_q <= wdata & IRQ_MASK;
      stat_q <= stat_next(stat_q, stat_we, wdata, evt);
    end
  end

  assign irq = active && |(stat_q & en_q);
endmodule

// File: rtl/legacy_tpm_regwin.sv
module legacy_tpm_regwin #(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] CAP_LO = 8'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_active,
  input  logic [7:0]        eng_sts,
  input  logic [7:0]        eng_burst,
  input  logic              eng_loc_act,
  input  logic [2:0]        eng_loc_id,
  input  logic [7:0]        fifo_rdata,
  output logic [7:0]        rd_data,
  output logic              rsp_valid,
  output logic              irq,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic [7:0]        fifo_wdata
);
  import tpmwin_pkg::*;

  logic       claim_rd, claim_wr;
  logic [2:0] ofs;
  logic [7:0] evt, en_q, stat_q;
  logic       en_we, stat_we;
  logic [7:0] rd_mux;

  tpmwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(io_addr), .base(cfg_base), .active(cfg_active),
    .rd(io_rd), .wr(io_wr),
    .claim_rd(claim_rd), .claim_wr(claim_wr), .ofs(ofs)
  );

  tpmwin_events u_evt (
    .clk(clk), .rst_n(rst_n), .sts(eng_sts),
    .loc_act(eng_loc_act), .loc_id(eng_loc_id), .evt(evt)
  );

  assign en_we   = claim_wr && (ofs == 3'(OFS_INT_EN));
  assign stat_we = claim_wr && (ofs == 3'(OFS_INT_STAT));

  tpmwin_irqregs u_irq (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .stat_we(stat_we),
    .wdata(io_wdata), .evt(evt), .active(cfg_active),
    .en_q(en_q), .stat_q(stat_q), .irq(irq)
  );

  always_comb begin
    case (ofs)
      3'(OFS_INT_EN):   rd_mux = en_q;
      3'(OFS_INT_STAT): rd_mux = stat_q;
      3'(OFS_CAP):      rd_mux = CAP_LO;
      3'(OFS_STS_LO):   rd_mux = eng_sts;
      3'(OFS_STS_HI):   rd_mux = eng_burst;
      3'(OFS_FIFO):     rd_mux = fifo_rdata;
      default:          rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rsp_valid  <= 1'b0;
      fifo_pop   <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      rd_data   <= claim_rd ? rd_mux : 8'h00;
      rsp_valid <= claim_rd || claim_wr;
      fifo_pop  <= claim_rd && (ofs == 3'(OFS_FIFO));
      fifo_push <= claim_wr && (ofs == 3'(OFS_FIFO));
      if (claim_wr && (ofs == 3'(OFS_FIFO))) fifo_wdata <= io_wdata;
    end
  end
endmodule

// File: rtl/tpmwin_chk.sv
module tpmwin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic       cfg_active,
  input logic [7:0] eng_sts,
  input logic       rsp_valid,
  input logic       irq,
  input logic       fifo_pop,
  input logic       fifo_push,
  input logic [7:0] stat_q,
  input logic       stat_we
);
  p_resp_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(io_rd || io_wr));

  p_inactive_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && (io_rd || io_wr)) |=> (!rsp_valid && !fifo_pop && !fifo_push));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> !irq);

  p_w1c_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[7]) |-> ($past(stat_we) && $past(io_wdata[7])));

  p_cmdrdy_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_sts[6]) |=> stat_q[7]);

  p_davail_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eng_sts[4]) && eng_sts[7]) |=> stat_q[0]);

  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop || fifo_push) |-> rsp_valid);
endmodule

bind legacy_tpm_regwin tpmwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
  .cfg_active(cfg_active), .eng_sts(eng_sts), .rsp_valid(rsp_valid), .irq(irq),
  .fifo_pop(fifo_pop), .fifo_push(fifo_push), .stat_q(stat_q), .stat_we(stat_we)
);

// File: tb/legacy_tpm_regwin_tb.sv
module legacy_tpm_regwin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] cfg_base = 16'h0EE0;
  logic        cfg_active = 1'b1;
  logic [7:0]  eng_sts = '0, eng_burst = 8'h3C;
  logic        eng_loc_act = 1'b0;
  logic [2:0]  eng_loc_id = '0;
  logic [7:0]  fifo_rdata = 8'hA5;
  logic [7:0]  rd_data, fifo_wdata;
  logic        rsp_valid, irq, fifo_pop, fifo_push;

  localparam logic [7:0] CAP_EXP = 8'h5F;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  legacy_tpm_regwin dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .cfg_base(cfg_base), .cfg_active(cfg_active),
    .eng_sts(eng_sts), .eng_burst(eng_burst), .eng_loc_act(eng_loc_act),
    .eng_loc_id(eng_loc_id), .fifo_rdata(fifo_rdata), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .irq(irq), .fifo_pop(fifo_pop),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic       s_rv, s_pop, s_push;
  logic [7:0] s_rd, s_pw;

  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = w; io_rd = !w;
    @(posedge clk);
    @(negedge clk);
    s_rv = rsp_valid; s_rd = rd_data; s_pop = fifo_pop;
    s_push = fifo_push; s_pw = fifo_wdata;
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic rd_reg(input int o, input logic [7:0] exp, input string req);
    acc(cfg_base + 16'(o), 1'b0, 8'h00);
    chk(s_rv === 1'b1, req, "read claimed", s_rv, 1);
    chk(s_rd === exp, req, "read value", s_rd, exp);
  endtask

  task automatic set_sts(input logic [7:0] v);
    @(negedge clk); eng_sts = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_loc(input bit act, input logic [2:0] id);
    @(negedge clk); eng_loc_act = act; eng_loc_id = id;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr_all();
    acc(cfg_base + 16'd1, 1'b1, 8'hFF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    chk(rsp_valid === 1'b0 && irq === 1'b0, "R4", "reset outputs", {rsp_valid, irq}, 0);
    rd_reg(0, 8'h00, "R4");
    rd_reg(1, 8'h00, "R5");

    // R1/R2 sweep for two bases, including top-of-space
    for (int b = 0; b < 2; b++) begin
      cfg_base = (b == 0) ? 16'h0EE0 : 16'hFFFC;
      for (int k = -3; k <= 9; k++) begin
        int full;
        bit exp_hit;
        logic [7:0] exp_d;
        full = int'(cfg_base) + k;
        exp_hit = (k >= 0) && (k <= 5) && (full <= 16'hFFFF);
        case (k)
          0: exp_d = 8'h00;
          1: exp_d = 8'h00;
          2: exp_d = CAP_EXP;
          3: exp_d = eng_sts;
          4: exp_d = eng_burst;
          default: exp_d = fifo_rdata;
        endcase
        acc(16'(full), 1'b0, 8'h00);
        chk(s_rv === exp_hit, exp_hit ? "R1" : "R2", "claim", s_rv, exp_hit);
        if (exp_hit) chk(s_rd === exp_d, "R1", "sweep data", s_rd, exp_d);
        chk(s_pop === (exp_hit && k == 5), "R11", "pop on sweep", s_pop, exp_hit && k == 5);
      end
    end
    cfg_base = 16'h0EE0;

    // R4 enable mask
    acc(cfg_base, 1'b1, 8'hFF);
    chk(s_rv === 1'b1, "R1", "write claimed", s_rv, 1);
    rd_reg(0, 8'h87, "R4");
    acc(cfg_base, 1'b1, 8'h55);
    rd_reg(0, 8'h05, "R4");
    // R2: out-of-window alias write changes nothing
    acc(cfg_base + 16'h0100, 1'b1, 8'hFF);
    chk(s_rv === 1'b0, "R2", "alias write response", s_rv, 0);
    acc(cfg_base + 16'd6, 1'b1, 8'hFF);
    chk(s_rv === 1'b0 && s_push === 1'b0, "R2", "offset 6 write", s_rv, 0);
    rd_reg(0, 8'h05, "R2");

    // R6 read-only offsets
    eng_burst = 8'hC3;
    acc(cfg_base + 16'd2, 1'b1, 8'h00);
    acc(cfg_base + 16'd4, 1'b1, 8'h00);
    rd_reg(2, CAP_EXP, "R6");
    rd_reg(4, 8'hC3, "R6");
    acc(cfg_base, 1'b1, 8'h00);

    // R7 command ready and status valid
    set_sts(8'h40);
    rd_reg(1, 8'h80, "R7");
    rd_reg(3, 8'h40, "R6");
    set_sts(8'hC0);
    rd_reg(1, 8'h82, "R7");
    acc(cfg_base + 16'd1, 1'b1, 8'h80);
    rd_reg(1, 8'h02, "R5");
    acc(cfg_base + 16'd1, 1'b1, 8'h00);
    rd_reg(1, 8'h02, "R5");
    clr_all();
    rd_reg(1, 8'h00, "R5");
    set_sts(8'h00);

    // R5 event beats clear in same cycle
    @(negedge clk);
    io_addr = cfg_base + 16'd1; io_wdata = 8'h80; io_wr = 1'b1; eng_sts = 8'h40;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0;
    rd_reg(1, 8'h80, "R5");
    clr_all(); set_sts(8'h00);

    // R8 data available qualification
    set_sts(8'h10);
    rd_reg(1, 8'h00, "R8");
    set_sts(8'h90);
    rd_reg(1, 8'h03, "R8");
    clr_all();
    set_sts(8'h80);
    set_sts(8'h90);
    rd_reg(1, 8'h01, "R8");
    clr_all(); set_sts(8'h00);
    set_sts(8'h90);
    rd_reg(1, 8'h03, "R8");
    clr_all(); set_sts(8'h00);

    // R9 locality change
    set_loc(1'b1, 3'd1);
    rd_reg(1, 8'h00, "R9");
    set_loc(1'b1, 3'd2);
    rd_reg(1, 8'h04, "R9");
    clr_all();
    set_loc(1'b0, 3'd2);
    rd_reg(1, 8'h00, "R9");
    set_loc(1'b1, 3'd0);
    rd_reg(1, 8'h04, "R9");
    clr_all();

    // R10 / R3 irq gating
    acc(cfg_base, 1'b1, 8'h80);
    chk(irq === 1'b0, "R10", "irq idle", irq, 0);
    set_sts(8'h40);
    chk(irq === 1'b1, "R10", "irq on enabled event", irq, 1);
    @(negedge clk); cfg_active = 1'b0;
    #1 chk(irq === 1'b0, "R3", "irq gated inactive", irq, 0);
    acc(cfg_base + 16'd1, 1'b0, 8'h00);
    chk(s_rv === 1'b0, "R3", "inactive no response", s_rv, 0);
    @(negedge clk); cfg_active = 1'b1;
    #1 chk(irq === 1'b1, "R10", "irq restored", irq, 1);
    acc(cfg_base, 1'b1, 8'h01);
    chk(irq === 1'b0, "R10", "irq masked", irq, 0);
    acc(cfg_base, 1'b1, 8'h80);
    clr_all();
    chk(irq === 1'b0, "R10", "irq after clear", irq, 0);
    set_sts(8'h00);

    // R11 FIFO strobes
    fifo_rdata = 8'h6E;
    acc(cfg_base + 16'd5, 1'b0, 8'h00);
    chk(s_pop === 1'b1 && s_rd === 8'h6E, "R11", "pop read", s_rd, 8'h6E);
    @(negedge clk);
    chk(fifo_pop === 1'b0, "R11", "pop one cycle", fifo_pop, 0);
    acc(cfg_base + 16'd5, 1'b1, 8'hB7);
    chk(s_push === 1'b1 && s_pw === 8'hB7, "R11", "push byte", s_pw, 8'hB7);
    chk(s_pop === 1'b0, "R11", "no pop on write", s_pop, 0);
    @(negedge clk);
    chk(fifo_push === 1'b0, "R11", "push one cycle", fifo_push, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule